// File: doc/BRIEF.md
# Multi-Pointer Data Address Generator

This block produces data memory addresses for a signal processing datapath. It holds a bank of independent pointer registers. Each pointer has its own base, length, signed modifier, addressing mode and transform size. Every cycle, each of several access ports may name a pointer and a direction. The port emits that pointer's current value as its address, and the pointer takes its post-modified value at the next clock edge. The update costs no extra cycle, whatever the mode.

Three modes exist. Linear mode steps the pointer by the modifier over the full address space. Circular mode keeps the pointer inside a buffer of any length, not only a power of two, and wraps in either direction. Bit-reversed mode walks the offset from base in the reverse-carry order used to reorder transform data, for sizes from 2 to 1024 points. Software programs the registers through a single write port. Writing a base or a length re-centres the pointer on its base.

Top module: `dag_addr_gen`

## Requirements
- R1: After reset every pointer reads 0, with base 0, length 1, modifier +1, linear mode and size code 1.
- R2: A port's address is the selected pointer's present value in the same cycle. The pointer moves only at the following clock edge (post-modify).
- R3: In linear mode (mode code 0) the step is +modifier for direction 0 and -modifier for direction 1. The modifier is two's complement, and the result wraps modulo 2^AW.
- R4: In circular mode (mode code 1), a step that reaches base+length or beyond subtracts length, for any |modifier| no larger than length.
- R5: In circular mode, a step that lands below base adds length, for any |modifier| no larger than length.
- R6: Circular wrap is exact for lengths that are not powers of two, and the pointer visits offsets (k*step) mod length.
- R7: In bit-reversed mode (mode code 2), the k-th access from base returns base plus the size-code-bit reversal of k mod 2^size. Direction has no effect. Size code 0 acts as 1 and codes above 10 act as 10.
- R8: Two ports that name different pointers in one cycle both get their addresses, and both pointers are updated.
- R9: When two ports name the same pointer, both see the same address and only the lowest-numbered port's update takes effect.
- R10: Config field codes are 0 base, 1 length, 2 modifier, 3 mode and 4 size code. Writing base or length sets the pointer to the base. Writing modifier, mode or size leaves the pointer where it is.
- R11: A pointer that no port selects and no config write touches keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ptr | input | PSEL_W | Pointer whose register is written |
| cfg_sel | input | 3 | Field code (0 base, 1 length, 2 modifier, 3 mode, 4 size) |
| cfg_data | input | AW | Write data |
| acc_valid | input | NPORT | Per-port access request |
| acc_ptr | input | NPORT*PSEL_W | Per-port pointer select, port 0 in the low bits |
| acc_dir | input | NPORT | Per-port direction, 0 forward, 1 backward |
| acc_addr | output | NPORT*AW | Per-port address, port 0 in the low bits |

## Verification
The bench builds the block with 16-bit addresses, four pointers and two ports. This makes every circular length from 1 to 8 reachable, together with every modifier from minus length to plus length in both directions, each run past two full wraps. Bit-reversed sequences are swept in full for several sizes, including the clamped size code 0. Wrap at the top of the 16-bit space, concurrent updates and same-pointer collisions are also reachable at this size.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int MAX_LOG = 10;

  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_CIRC   = 2'd1,
    AM_BITREV = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;

  localparam logic [2:0] CF_BASE = 3'd0;
  localparam logic [2:0] CF_LEN  = 3'd1;
  localparam logic [2:0] CF_MOD  = 3'd2;
  localparam logic [2:0] CF_MODE = 3'd3;
  localparam logic [2:0] CF_FFT  = 3'd4;

  // size code limited to 1..MAX_LOG
  function automatic logic [3:0] clamp_log(input logic [3:0] lg);
    if (lg == 4'd0) return 4'd1;
    if (lg > 4'(MAX_LOG)) return 4'(MAX_LOG);
    return lg;
  endfunction

  // add one at the top bit of an lg-bit field, carry running downwards
  function automatic logic [MAX_LOG-1:0] rev_carry_inc(input logic [MAX_LOG-1:0] off,
                                                       input logic [3:0] lg);
    logic [MAX_LOG-1:0] r;
    logic c;
    r = '0;
    c = 1'b1;
    for (int i = MAX_LOG - 1; i >= 0; i--) begin
      if (i < int'(lg)) begin
        r[i] = off[i] ^ c;
        c    = off[i] & c;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/dag_req_router.sv
module dag_req_router #(
  parameter int NPORT  = 2,
  parameter int NPTR   = 4,
  parameter int PSEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        acc_valid,
  input  logic [NPORT*PSEL_W-1:0] acc_ptr,
  input  logic [NPORT-1:0]        acc_dir,
  output logic [NPTR-1:0]         upd,
  output logic [NPTR-1:0]         upd_dir
);
  // descending scan so the lowest port is applied last and wins
  always_comb begin
    upd     = '0;
    upd_dir = '0;
    for (int q = NPORT - 1; q >= 0; q--) begin
      if (acc_valid[q]) begin
        upd[acc_ptr[q*PSEL_W +: PSEL_W]]     = 1'b1;
        upd_dir[acc_ptr[q*PSEL_W +: PSEL_W]] = acc_dir[q];
      end
    end
  end

  generate
    if (NPORT >= 2) begin : g_pair_chk
      logic [PSEL_W-1:0] sel0, sel1;
      logic both_distinct, both_same;
      assign sel0 = acc_ptr[0 +: PSEL_W];
      assign sel1 = acc_ptr[PSEL_W +: PSEL_W];
      assign both_distinct = acc_valid[0] && acc_valid[1] && (sel0 != sel1);
      assign both_same     = acc_valid[0] && acc_valid[1] && (sel0 == sel1);

      p_dual_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        both_distinct |-> (upd[sel0] && upd[sel1] && $countones(upd) >= 2));

      p_port0_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        both_same |-> (upd_dir[sel0] == acc_dir[0]));
    end
  endgenerate
endmodule

// File: rtl/dag_ptr_unit.sv
module dag_ptr_unit
  import dag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_hit,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          upd,
  input  logic          dir,
  output logic [AW-1:0] ptr
);
  localparam int EW = AW + 2;

  logic [AW-1:0] base_q, len_q, mod_q;
  amode_e        mode_q;
  logic [3:0]    lg_q;
  logic [AW-1:0] nxt;

  function automatic logic signed [EW-1:0] signed_step(input logic [AW-1:0] m, input logic d);
    logic signed [EW-1:0] s;
    s = $signed({{2{m[AW-1]}}, m});
    return d ? -s : s;
  endfunction

  function automatic logic [AW-1:0] circ_next(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                              input logic [AW-1:0] l,
                                              input logic signed [EW-1:0] st);
    logic signed [EW-1:0] sum, lo, hi, le;
    le  = $signed({2'b00, l});
    lo  = $signed({2'b00, b});
    hi  = lo + le;
    sum = $signed({2'b00, p}) + st;
    if (sum >= hi)      sum = sum - le;
    else if (sum < lo)  sum = sum + le;
    return sum[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] brev_next(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                              input logic [3:0] lg);
    logic [AW-1:0] off;
    logic [MAX_LOG-1:0] no;
    off = p - b;
    no  = rev_carry_inc(off[MAX_LOG-1:0], clamp_log(lg));
    return b + {{(AW-MAX_LOG){1'b0}}, no};
  endfunction

  always_comb begin
    case (mode_q)
      AM_CIRC:   nxt = circ_next(ptr, base_q, len_q, signed_step(mod_q, dir));
      AM_BITREV: nxt = brev_next(ptr, base_q, lg_q);
      default:   nxt = ptr + AW'(signed_step(mod_q, dir));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= AW'(1);
      mod_q  <= AW'(1);
      mode_q <= AM_LINEAR;
      lg_q   <= 4'd1;
      ptr    <= '0;
    end else if (cfg_hit) begin
      case (cfg_sel)
        CF_BASE: begin base_q <= cfg_data; ptr <= cfg_data; end
        CF_LEN:  begin len_q  <= cfg_data; ptr <= base_q;   end
        CF_MOD:  mod_q  <= cfg_data;
        CF_MODE: mode_q <= amode_e'(cfg_data[1:0]);
        CF_FFT:  lg_q   <= cfg_data[3:0];
        default: ;
      endcase
    end else if (upd) begin
      ptr <= nxt;
    end
  end

  // named events for the checks below
  logic          rebase_evt, step_evt, circ_in_range, circ_mod_ok, brev_in_window;
  logic [AW:0]   mod_abs;
  logic [AW-1:0] brev_off;
  assign rebase_evt    = cfg_hit && (cfg_sel == CF_BASE || cfg_sel == CF_LEN);
  assign step_evt      = upd && !cfg_hit;
  assign circ_in_range = (ptr >= base_q) &&
                         ({1'b0, ptr} < ({1'b0, base_q} + {1'b0, len_q}));
  assign mod_abs       = mod_q[AW-1] ? ({1'b0, ~mod_q} + 1'b1) : {1'b0, mod_q};
  assign circ_mod_ok   = (len_q != '0) && (mod_abs <= {1'b0, len_q});
  assign brev_off      = ptr - base_q;
  assign brev_in_window = ({{(AW){1'b0}}, brev_off} >> clamp_log(lg_q)) == '0;

  p_circ_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == AM_CIRC && circ_in_range && circ_mod_ok) |=> circ_in_range);

  p_brev_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == AM_BITREV && brev_in_window) |=> brev_in_window);

  p_rebase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rebase_evt |=> (ptr == base_q));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !cfg_hit) |=> $stable(ptr));
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen #(
  parameter int AW    = 16,
  parameter int NPTR  = 4,
  parameter int NPORT = 2,
  localparam int PSEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [PSEL_W-1:0]       cfg_ptr,
  input  logic [2:0]              cfg_sel,
  input  logic [AW-1:0]           cfg_data,
  input  logic [NPORT-1:0]        acc_valid,
  input  logic [NPORT*PSEL_W-1:0] acc_ptr,
  input  logic [NPORT-1:0]        acc_dir,
  output logic [NPORT*AW-1:0]     acc_addr
);
  logic [NPTR-1:0] upd, upd_dir;
  logic [AW-1:0]   ptr_q [NPTR];

  dag_req_router #(.NPORT(NPORT), .NPTR(NPTR), .PSEL_W(PSEL_W)) router_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ptr(acc_ptr), .acc_dir(acc_dir),
    .upd(upd), .upd_dir(upd_dir)
  );

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic hit;
      assign hit = cfg_we && (cfg_ptr == PSEL_W'(g));
      dag_ptr_unit #(.AW(AW)) unit_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_hit(hit), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .upd(upd[g]), .dir(upd_dir[g]),
        .ptr(ptr_q[g])
      );
    end
    for (genvar q = 0; q < NPORT; q++) begin : g_port
      assign acc_addr[q*AW +: AW] = ptr_q[acc_ptr[q*PSEL_W +: PSEL_W]];
    end
  endgenerate
endmodule

// File: tb/dag_addr_gen_tb_top.sv
module dag_addr_gen_tb_top;
  localparam int AW = 16, NPTR = 4, NPORT = 2, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [PW-1:0] cfg_ptr = '0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [NPORT-1:0] acc_valid = '0;
  logic [NPORT*PW-1:0] acc_ptr = '0;
  logic [NPORT-1:0] acc_dir = '0;
  logic [NPORT*AW-1:0] acc_addr;

  int checks = 0, errors = 0;
  int got0, got1;
  bit done = 0;

  always #10 clk = ~clk;

  dag_addr_gen #(.AW(AW), .NPTR(NPTR), .NPORT(NPORT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ptr(cfg_ptr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .acc_valid(acc_valid), .acc_ptr(acc_ptr), .acc_dir(acc_dir),
    .acc_addr(acc_addr));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cfg(input int p, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ptr = PW'(p); cfg_sel = 3'(sel); cfg_data = AW'(data);
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic acc(input bit v0, input int p0, input bit d0,
                     input bit v1, input int p1, input bit d1);
    @(negedge clk);
    acc_valid = {v1, v0}; acc_ptr = {PW'(p1), PW'(p0)}; acc_dir = {d1, d0};
    #1;
    got0 = int'(acc_addr[0 +: AW]);
    got1 = int'(acc_addr[AW +: AW]);
    @(posedge clk); #2;
    acc_valid = '0;
  endtask

  function automatic int brev(input int k, input int lg);
    int r = 0;
    for (int i = 0; i < lg; i++) r = (r << 1) | ((k >> i) & 1);
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state, peeked without requests
    for (int p = 0; p < NPTR; p++) begin
      acc(0, p, 0, 0, 0, 0);
      check("R1 reset ptr", got0, 0);
    end
    // R1 default mode linear, modifier +1
    acc(1, 3, 0, 0, 0, 0); check("R1 default step", got0, 0);
    acc(0, 3, 0, 0, 0, 0); check("R1 default step", got0, 1);

    // R2/R3 linear forward and backward
    cfg(0, 0, 100); cfg(0, 2, 3);
    e = 100;
    for (int k = 0; k < 6; k++) begin acc(1, 0, 0, 0, 0, 0); check("R2 R3 inc", got0, e); e += 3; end
    for (int k = 0; k < 8; k++) begin acc(1, 0, 1, 0, 0, 0); check("R3 dec", got0, e); e -= 3; end
    cfg(0, 2, 16'hFFFE); // modifier -2, direction 1 makes +2
    for (int k = 0; k < 3; k++) begin acc(1, 0, 1, 0, 0, 0); check("R3 neg mod", got0, e); e += 2; end
    cfg(0, 0, 16'hFFFD); cfg(0, 2, 3);
    e = 16'hFFFD;
    for (int k = 0; k < 4; k++) begin acc(1, 0, 0, 0, 0, 0); check("R3 wrap 2^AW", got0, e); e = (e + 3) & 16'hFFFF; end

    // R4 R5 R6 circular sweep over lengths and modifiers
    for (int len = 1; len <= 8; len++) begin
      for (int m = -len; m <= len; m++) begin
        for (int d = 0; d < 2; d++) begin
          int off, s;
          cfg(1, 0, 200); cfg(1, 1, len); cfg(1, 2, m & 16'hFFFF); cfg(1, 3, 1);
          s = d ? -m : m;
          off = 0;
          for (int k = 0; k < 2 * len + 3; k++) begin
            acc(0, 0, 0, 1, 1, d[0]);
            check(s >= 0 ? "R4 R6 circ fwd" : "R5 R6 circ back", got1, 200 + off);
            off = (((off + s) % len) + len) % len;
          end
        end
      end
    end

    // R7 bit-reversed sequences, direction alternated and ignored
    for (int lg = 0; lg <= 5; lg++) begin
      int el, n;
      el = (lg == 0) ? 1 : lg;
      n = 1 << el;
      cfg(2, 0, 64); cfg(2, 3, 2); cfg(2, 4, lg);
      for (int k = 0; k < 2 * n; k++) begin
        acc(1, 2, k[0], 0, 0, 0);
        check("R7 bitrev", got0, 64 + brev(k % n, el));
      end
    end

    // R8 two pointers at once
    cfg(0, 3, 0); cfg(0, 0, 10); cfg(0, 2, 1);
    cfg(3, 0, 500); cfg(3, 2, 4);
    acc(1, 0, 0, 1, 3, 1);
    check("R8 port0 addr", got0, 10); check("R8 port1 addr", got1, 500);
    acc(0, 0, 0, 0, 3, 0);
    check("R8 ptr0 moved", got0, 11); check("R8 ptr3 moved", got1, 496);

    // R9 same pointer on both ports: port 0 (forward) wins
    acc(1, 3, 0, 1, 3, 1);
    check("R9 shared addr p0", got0, 496); check("R9 shared addr p1", got1, 496);
    acc(0, 3, 0, 0, 0, 0);
    check("R9 port0 wins", got0, 500);

    // R10 modifier/mode/size writes keep the pointer, length write rebases
    cfg(3, 2, 7); cfg(3, 4, 3); cfg(3, 3, 0);
    acc(0, 3, 0, 0, 0, 0); check("R10 keep ptr", got0, 500);
    acc(1, 3, 0, 0, 0, 0); acc(0, 3, 0, 0, 0, 0); check("R10 new mod", got0, 507);
    cfg(3, 1, 9);
    acc(0, 3, 0, 0, 0, 0); check("R10 len rebase", got0, 500);
    cfg(3, 0, 1234);
    acc(0, 3, 0, 0, 0, 0); check("R10 base rebase", got0, 1234);

    // R11 idle pointers hold
    repeat (5) @(posedge clk);
    acc(0, 3, 0, 0, 0, 0); check("R11 hold", got0, 1234);
    acc(0, 0, 0, 0, 0, 0); check("R11 hold other", got0, 11);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule